// File: doc/BRIEF.md
# Multi-Pattern Test Sequence Generator

This block produces the transmit side of a bit-error-rate test stream for a framed TDM path. A slot strobe marks each bit slot. A per-slot channel enable comes from a channel assignment map, and a per-bit suppress mask can remove individual bit positions inside a channel. Together they decide which slots carry test data. The generator emits one registered bit with a valid flag for every slot that is strobed, enabled and not suppressed. The sequence moves forward only on those slots, so it stays continuous across skipped slots.

One configuration write selects the pattern source and loads its parameters. The sources are:
- four maximal-length pseudorandom sequences;
- a quasi-random variant whose zero runs are limited to 14;
- a repeating pattern of 1 to 32 bits;
- two alternating 16-bit words that swap after a programmable number of words.

Each configuration write restarts the selected source from its seed.

Top module: `bert_patgen`

## Requirements
- R1: After reset, `out_valid` and `out_bit` are 0. The block behaves as mode 0 with an all-ones 32-bit pattern, a repeat length code of 31 and a word count code of 0.
- R2: A slot qualifies when `slot_strobe`=1, `chan_en`=1, `bit_mask`=0 and `cfg_we`=0. The clock edge that samples a qualifying slot sets `out_valid`=1 and presents that slot's pattern bit on `out_bit`. Every other edge sets `out_valid`=0 and `out_bit`=0.
- R3: The pattern advances by exactly one bit per qualifying slot. Non-qualifying slots leave it unchanged, so the valid bits form one unbroken sequence.
- R4: Each pseudorandom mode follows the recurrence b[i] = b[i-n] XOR b[i-k]. The modes map to (n, k) as follows: mode 0 = (7,6), mode 1 = (9,5), mode 2 = (11,9), mode 3 = (15,14), mode 4 = (20,17). Unused code 7 acts as mode 0.
- R5: Mode 4 (quasi-random) emits a 1 in place of a generated 0 when the 14 bits emitted just before were all 0. A forced bit restarts the zero run; the recurrence itself still uses the generated bits. Seed 00001h therefore emits 14 zeros, then 1, 0, 1.
- R6: The first n emitted bits of a pseudorandom mode are generated from an initial history taken from `cfg_pattern[n-1:0]`. Bit j of the field is the bit j+1 steps back. An all-zero field is replaced by all ones.
- R7: Mode 5 (repeat) emits `cfg_pattern[0]`, `[1]` … `[L]` and then wraps to bit 0, where L = `cfg_rep_len` (period L+1). Pattern 5AD6B5ADh with L = 4 emits 1,0,1,1,0 repeatedly.
- R8: Mode 6 (alternating) has word A = `cfg_pattern[15:0]` and word B = `cfg_pattern[31:16]`. Each word is sent LSB first. The output starts with A and swaps words after `cfg_word_cnt`+1 complete words. Words 0000h and 7E7Eh with a count code of 49 give 800 zero bits followed by 800 bits of 7E7Eh.
- R9: The edge that samples `cfg_we`=1 loads all configuration fields and restarts the selected source from its first bit. That edge gives `out_valid`=0, even when a slot is strobed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write and restart strobe |
| cfg_mode | input | 3 | Pattern source code |
| cfg_pattern | input | 32 | Pattern, seed or word pair |
| cfg_rep_len | input | 5 | Repeat length minus one |
| cfg_word_cnt | input | 8 | Alternating word count minus one |
| slot_strobe | input | 1 | Bit slot present this cycle |
| chan_en | input | 1 | Slot belongs to an assigned channel |
| bit_mask | input | 1 | Suppress this bit position |
| out_bit | output | 1 | Test data bit |
| out_valid | output | 1 | Test data bit is valid |

## Verification
Every result lands exactly one clock edge after the slot or configuration write that causes it. This covers the data bit, the valid flag and the suppression of output during a reload. The bench drives inputs just after each rising edge. A behavioural model updates on that same rising edge, and the outputs are compared with the model at the following falling edge, so every comparison falls on the cycle in which the result is due. Bits are also captured at those falling edges, whenever valid is high, for the directed checks:
- the tiled 5-bit pattern;
- the 800-bit word swap;
- the forced one after 14 zeros;
- identical output for an all-zero seed and an all-ones seed;
- a restart after reload.

// File: rtl/bert_patgen_pkg.sv
package bert_patgen_pkg;

    localparam int LFSR_W         = 20;
    localparam int QRSS_MAX_ZEROS = 14;
    localparam int PAT_W          = 32;
    localparam int CNT_W          = 8;

    typedef enum logic [2:0] {
        MODE_PRBS7   = 3'd0,
        MODE_PRBS9   = 3'd1,
        MODE_PRBS11  = 3'd2,
        MODE_PRBS15  = 3'd3,
        MODE_QRSS    = 3'd4,
        MODE_REPEAT  = 3'd5,
        MODE_ALTWORD = 3'd6,
        MODE_SPARE   = 3'd7
    } bert_mode_e;

    // register length n of the recurrence
    function automatic logic [4:0] prbs_len(bert_mode_e m);
        case (m)
            MODE_PRBS9:  prbs_len = 5'd9;
            MODE_PRBS11: prbs_len = 5'd11;
            MODE_PRBS15: prbs_len = 5'd15;
            MODE_QRSS:   prbs_len = 5'd20;
            default:     prbs_len = 5'd7;
        endcase
    endfunction

    // feedback tap k of the recurrence
    function automatic logic [4:0] prbs_tap(bert_mode_e m);
        case (m)
            MODE_PRBS9:  prbs_tap = 5'd5;
            MODE_PRBS11: prbs_tap = 5'd9;
            MODE_PRBS15: prbs_tap = 5'd14;
            MODE_QRSS:   prbs_tap = 5'd17;
            default:     prbs_tap = 5'd6;
        endcase
    endfunction

endpackage

// File: rtl/bert_lfsr_engine.sv
module bert_lfsr_engine
    import bert_patgen_pkg::*;
#(
    parameter int W    = LFSR_W,
    parameter int MAXZ = QRSS_MAX_ZEROS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic             advance_i,
    input  bert_mode_e       mode_i,
    input  logic [W-1:0]     seed_i,
    output logic             bit_o
);

    localparam int ZW = $clog2(MAXZ + 1);

    typedef struct packed {
        bert_mode_e    mode;
        logic [W-1:0]  sr;
        logic [ZW-1:0] zrun;
    } lfsr_state_t;

    lfsr_state_t s_d, s_q;

    logic [4:0]   n_len;
    logic [4:0]   k_tap;
    logic         raw;
    logic         force_one;
    logic [W-1:0] len_mask;
    logic [W-1:0] seed_m;

    always_comb begin
        n_len     = prbs_len(s_q.mode);
        k_tap     = prbs_tap(s_q.mode);
        raw       = s_q.sr[n_len - 5'd1] ^ s_q.sr[k_tap - 5'd1];
        force_one = (s_q.mode == MODE_QRSS) && !raw && (s_q.zrun == ZW'(MAXZ));
        bit_o     = raw | force_one;

        len_mask  = (W'(1) << prbs_len(mode_i)) - W'(1);
        seed_m    = seed_i & len_mask;

        s_d = s_q;
        if (reload_i) begin
            s_d.mode = mode_i;
            s_d.sr   = (seed_m == '0) ? len_mask : seed_m;
            s_d.zrun = '0;
        end else if (advance_i) begin
            s_d.sr = {s_q.sr[W-2:0], raw};
            if (s_q.mode == MODE_QRSS && !bit_o) begin
                s_d.zrun = s_q.zrun + ZW'(1);
            end else begin
                s_d.zrun = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= MODE_PRBS7;
            s_q.sr   <= '1;
            s_q.zrun <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: the shift register never locks up in the all-zero state
    p_no_lockup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sr != '0);

    // R5: the run of emitted zeros never passes the limit
    p_zero_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.zrun <= ZW'(MAXZ));

    // R3: no movement without a qualifying slot or reload
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !reload_i) |=> $stable(s_q.sr));

endmodule

// File: rtl/bert_word_engine.sv
module bert_word_engine
    import bert_patgen_pkg::*;
#(
    parameter int PW = PAT_W,
    parameter int CW = CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reload_i,
    input  logic                    advance_i,
    input  logic                    alt_i,
    input  logic [PW-1:0]           pattern_i,
    input  logic [$clog2(PW)-1:0]   rep_len_i,
    input  logic [CW-1:0]           word_cnt_i,
    output logic                    bit_o
);

    localparam int IDX_W  = $clog2(PW);
    localparam int WORD_W = PW / 2;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [PW-1:0]    pat;
        logic [IDX_W-1:0] len;
        logic [CW-1:0]    wcnt;
        logic [IDX_W-1:0] ridx;
        logic [BIT_W-1:0] bidx;
        logic [CW-1:0]    wc;
        logic             sel;
    } word_state_t;

    word_state_t s_d, s_q;

    always_comb begin
        if (alt_i) begin
            bit_o = s_q.pat[{s_q.sel, s_q.bidx}];
        end else begin
            bit_o = s_q.pat[s_q.ridx];
        end

        s_d = s_q;
        if (reload_i) begin
            s_d.pat  = pattern_i;
            s_d.len  = rep_len_i;
            s_d.wcnt = word_cnt_i;
            s_d.ridx = '0;
            s_d.bidx = '0;
            s_d.wc   = '0;
            s_d.sel  = 1'b0;
        end else if (advance_i) begin
            s_d.ridx = (s_q.ridx == s_q.len) ? '0 : s_q.ridx + IDX_W'(1);
            s_d.bidx = s_q.bidx + BIT_W'(1);
            if (s_q.bidx == '1) begin
                if (s_q.wc == s_q.wcnt) begin
                    s_d.wc  = '0;
                    s_d.sel = ~s_q.sel;
                end else begin
                    s_d.wc = s_q.wc + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pat  <= '1;
            s_q.len  <= '1;
            s_q.wcnt <= '0;
            s_q.ridx <= '0;
            s_q.bidx <= '0;
            s_q.wc   <= '0;
            s_q.sel  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: the repeat index stays within the programmed length
    p_rep_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ridx <= s_q.len);

    // R8: the word counter stays within the programmed count
    p_word_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wc <= s_q.wcnt);

    // R3: counters hold on non-qualifying slots
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !reload_i) |=> ($stable(s_q.ridx) && $stable(s_q.bidx) && $stable(s_q.sel)));

endmodule

// File: rtl/bert_patgen.sv
module bert_patgen
    import bert_patgen_pkg::*;
#(
    parameter int PW = PAT_W,
    parameter int CW = CNT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_mode,
    input  logic [PW-1:0]         cfg_pattern,
    input  logic [$clog2(PW)-1:0] cfg_rep_len,
    input  logic [CW-1:0]         cfg_word_cnt,
    input  logic                  slot_strobe,
    input  logic                  chan_en,
    input  logic                  bit_mask,
    output logic                  out_bit,
    output logic                  out_valid
);

    typedef struct packed {
        bert_mode_e mode;
        logic       valid;
        logic       dbit;
    } top_state_t;

    top_state_t s_d, s_q;

    logic qualify;
    logic advance;
    logic lfsr_bit;
    logic word_bit;
    logic use_word;
    logic alt_sel;

    bert_lfsr_engine #(
        .W    (LFSR_W),
        .MAXZ (QRSS_MAX_ZEROS)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload_i  (cfg_we),
        .advance_i (advance),
        .mode_i    (bert_mode_e'(cfg_mode)),
        .seed_i    (cfg_pattern[LFSR_W-1:0]),
        .bit_o     (lfsr_bit)
    );

    bert_word_engine #(
        .PW (PW),
        .CW (CW)
    ) u_word (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_i   (cfg_we),
        .advance_i  (advance),
        .alt_i      (alt_sel),
        .pattern_i  (cfg_pattern),
        .rep_len_i  (cfg_rep_len),
        .word_cnt_i (cfg_word_cnt),
        .bit_o      (word_bit)
    );

    always_comb begin
        qualify  = slot_strobe && chan_en && !bit_mask;
        advance  = qualify && !cfg_we;
        alt_sel  = (s_q.mode == MODE_ALTWORD);
        use_word = (s_q.mode == MODE_REPEAT) || alt_sel;

        s_d       = s_q;
        s_d.mode  = cfg_we ? bert_mode_e'(cfg_mode) : s_q.mode;
        s_d.valid = advance;
        s_d.dbit  = advance && (use_word ? word_bit : lfsr_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode  <= MODE_PRBS7;
            s_q.valid <= 1'b0;
            s_q.dbit  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_bit   = s_q.dbit;
    assign out_valid = s_q.valid;

    // R2: valid only follows a qualifying slot
    p_valid_on_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(slot_strobe && chan_en && !bit_mask));

    // R2: data is held low when not valid
    p_quiet_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_bit);

    // R9: a configuration write blocks output on that edge
    p_reload_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !out_valid);

endmodule

// File: tb/bert_patgen_test.sv
`timescale 1ns/1ps
module bert_patgen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic [31:0] cfg_pattern = 32'hFFFF_FFFF;
    logic [4:0]  cfg_rep_len = 5'd31;
    logic [7:0]  cfg_word_cnt = 8'd0;
    logic        slot_strobe = 1'b0;
    logic        chan_en = 1'b0;
    logic        bit_mask = 1'b0;
    logic        out_bit;
    logic        out_valid;

    always #2.5 clk = ~clk;

    bert_patgen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_mode     (cfg_mode),
        .cfg_pattern  (cfg_pattern),
        .cfg_rep_len  (cfg_rep_len),
        .cfg_word_cnt (cfg_word_cnt),
        .slot_strobe  (slot_strobe),
        .chan_en      (chan_en),
        .bit_mask     (bit_mask),
        .out_bit      (out_bit),
        .out_valid    (out_valid)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 1'b0;
    string cur_req  = "R1";

    // ---------------- behavioural reference model ----------------
    int   m_mode;
    int   m_pat;
    int   m_len;
    int   m_wcnt;
    int   hist[$];
    int   zrun, ridx, bidx, wc, sel;
    logic exp_valid = 1'b0;
    logic exp_bit   = 1'b0;

    function automatic int rec_n(int md);
        case (md) 1: return 9; 2: return 11; 3: return 15; 4: return 20; default: return 7; endcase
    endfunction
    function automatic int rec_k(int md);
        case (md) 1: return 5; 2: return 9; 3: return 14; 4: return 17; default: return 6; endcase
    endfunction

    task automatic m_restart();
        int n = rec_n(m_mode);
        int s = m_pat & ((1 << n) - 1);
        if (s == 0) s = (1 << n) - 1;
        hist.delete();
        for (int j = 0; j < 20; j++) hist.push_back((s >> j) & 1);
        zrun = 0; ridx = 0; bidx = 0; wc = 0; sel = 0;
    endtask

    function automatic int m_next();
        int b;
        if (m_mode == 5) begin
            b = (m_pat >> ridx) & 1;
            ridx = (ridx == m_len) ? 0 : ridx + 1;
        end else if (m_mode == 6) begin
            b = (m_pat >> (bidx + (sel ? 16 : 0))) & 1;
            bidx++;
            if (bidx == 16) begin
                bidx = 0;
                if (wc == m_wcnt) begin wc = 0; sel ^= 1; end else wc++;
            end
        end else begin
            int raw = hist[rec_n(m_mode) - 1] ^ hist[rec_k(m_mode) - 1];
            hist.push_front(raw);
            void'(hist.pop_back());
            b = raw;
            if (m_mode == 4) begin
                if (raw == 0 && zrun == 14) b = 1;
                zrun = (b == 0) ? zrun + 1 : 0;
            end
        end
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pat = 32'hFFFF_FFFF; m_len = 31; m_wcnt = 0;
            m_restart();
            exp_valid = 0; exp_bit = 0;
        end else if (cfg_we) begin
            m_mode = int'(cfg_mode); m_pat = int'(cfg_pattern);
            m_len = int'(cfg_rep_len); m_wcnt = int'(cfg_word_cnt);
            m_restart();
            exp_valid = 0; exp_bit = 0;
        end else if (slot_strobe && chan_en && !bit_mask) begin
            exp_valid = 1;
            exp_bit = logic'(m_next());
        end else begin
            exp_valid = 0; exp_bit = 0;
        end
    end

    // ---------------- per-cycle comparison and capture ----------------
    int cap[$];
    always @(negedge clk) begin
        if (!finished) begin
            n_checks++;
            if (out_valid !== exp_valid || out_bit !== exp_bit) begin
                n_fails++;
                $display("FAIL %s: valid/bit actual %b/%b expected %b/%b at %0t",
                         cur_req, out_valid, out_bit, exp_valid, exp_bit, $time);
            end
            if (out_valid === 1'b1) cap.push_back(int'(out_bit));
        end
    end

    task automatic chk(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // ---------------- stimulus ----------------
    int lcg = 12345;
    function automatic int rnd();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 16) & 32'h7FFF;
    endfunction

    task automatic cfg(int md, logic [31:0] pat, int len, int wcnt, bit strobe);
        cfg_we = 1; cfg_mode = 3'(md); cfg_pattern = pat;
        cfg_rep_len = 5'(len); cfg_word_cnt = 8'(wcnt);
        slot_strobe = strobe; chan_en = strobe; bit_mask = 0;
        @(posedge clk); #1;
        cfg_we = 0; slot_strobe = 0; chan_en = 0;
        @(posedge clk); #1;
        cap.delete();
    endtask

    task automatic run(int n, int kind);
        for (int i = 0; i < n; i++) begin
            if (kind == 0) begin
                slot_strobe = 1; chan_en = 1; bit_mask = 0;
            end else begin
                int r = rnd();
                slot_strobe = (r & 3) != 0;
                chan_en     = ((r >> 2) & 3) != 0;
                bit_mask    = ((r >> 4) & 3) == 0;
            end
            @(posedge clk); #1;
        end
        slot_strobe = 0; chan_en = 0; bit_mask = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
    endtask

    int ref20[$];
    int tmp[$];

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        chk(out_valid === 1'b0 && out_bit === 1'b0, "R1 reset outputs", int'(out_valid), 0);
        rst_n = 1;
        @(posedge clk); #1;

        // R1/R4: default mode after reset is 2^7-1 from all ones
        cur_req = "R1 default PRBS7";
        cap.delete();
        run(300, 0);
        chk(cap.size() == 300, "R2 valid count", cap.size(), 300);
        for (int i = 0; i < 20; i++) ref20.push_back(cap[i]);

        // R3: gated slots keep the sequence continuous
        cur_req = "R3 gated PRBS7";
        cfg(0, 32'hFFFF_FFFF, 0, 0, 0);
        run(500, 1);
        for (int i = 0; i < 20; i++)
            chk(cap[i] == ref20[i], "R3 continuity", cap[i], ref20[i]);

        // R4: other lengths
        cur_req = "R4 PRBS9";
        cfg(1, 32'hFFFF_FFFF, 0, 0, 0); run(700, 1);
        cur_req = "R4 PRBS11";
        cfg(2, 32'hFFFF_FFFF, 0, 0, 0); run(2200, 0);
        cur_req = "R4 PRBS15";
        cfg(3, 32'hFFFF_FFFF, 0, 0, 0); run(700, 1);
        cur_req = "R4 spare code";
        cfg(7, 32'hFFFF_FFFF, 0, 0, 0); run(40, 0);
        for (int i = 0; i < 20; i++)
            chk(cap[i] == ref20[i], "R4 spare as mode 0", cap[i], ref20[i]);

        // R5: quasi-random forcing
        cur_req = "R5 QRSS seed 1";
        cfg(4, 32'h0000_0001, 0, 0, 0);
        run(40, 0);
        for (int i = 0; i < 14; i++) chk(cap[i] == 0, "R5 leading zeros", cap[i], 0);
        chk(cap[14] == 1, "R5 forced one", cap[14], 1);
        chk(cap[15] == 0, "R5 after force", cap[15], 0);
        chk(cap[16] == 1, "R5 generated one", cap[16], 1);
        cur_req = "R5 QRSS long";
        cfg(4, 32'hFFFF_FFFF, 0, 0, 0);
        run(3000, 1);

        // R6: zero seed behaves as all ones
        cur_req = "R6 zero seed";
        cfg(0, 32'h0000_0000, 0, 0, 0);
        run(30, 0);
        for (int i = 0; i < 20; i++)
            chk(cap[i] == ref20[i], "R6 zero seed", cap[i], ref20[i]);

        // R7: repeating pattern
        cur_req = "R7 repeat 5";
        cfg(5, 32'h5AD6_B5AD, 4, 0, 0);
        run(60, 0);
        begin
            int exp5[5] = '{1, 0, 1, 1, 0};
            for (int i = 0; i < 50; i++)
                chk(cap[i] == exp5[i % 5], "R7 5-bit pattern", cap[i], exp5[i % 5]);
        end
        cur_req = "R7 repeat 1";
        cfg(5, 32'h0000_0001, 0, 0, 0); run(20, 1);
        cur_req = "R7 repeat 32";
        cfg(5, 32'hC35A_9E01, 31, 0, 0); run(200, 1);

        // R8: alternating words
        cur_req = "R8 alt 50";
        cfg(6, 32'h7E7E_0000, 0, 49, 0);
        run(1700, 0);
        begin
            int nz = 0;
            for (int i = 0; i < 800; i++) nz += cap[i];
            chk(nz == 0, "R8 first 800 zero", nz, 0);
            for (int i = 0; i < 16; i++)
                chk(cap[800 + i] == ((16'h7E7E >> i) & 1), "R8 word B", cap[800 + i], (16'h7E7E >> i) & 1);
            chk(cap[1599] == 0, "R8 last of B", cap[1599], 0);
            chk(cap[1600] == 0, "R8 back to A", cap[1600], 0);
        end
        cur_req = "R8 alt 1";
        cfg(6, 32'hA5C3_0F0F, 0, 0, 0); run(300, 1);
        cur_req = "R8 alt 256";
        cfg(6, 32'h1234_ABCD, 0, 255, 0); run(8400, 0);

        // R9: reload with a strobe in the same cycle restarts
        cur_req = "R9 reload";
        cfg(3, 32'hFFFF_FFFF, 0, 0, 0);
        run(50, 0);
        cfg(0, 32'hFFFF_FFFF, 0, 0, 1);
        run(25, 0);
        for (int i = 0; i < 20; i++)
            chk(cap[i] == ref20[i], "R9 restart", cap[i], ref20[i]);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule